// File: doc/BRIEF.md
# Low-Power Entry Sequencer

This block takes a network controller into its wake-capable low-power state after a single start pulse. It steps through a fixed order of level outputs. First it halts the receive processor's clock. Then it hands internal clocking over to an alternate reference and puts the main PLL into its low-power mode. After that it requests the move from main to auxiliary supply and turns the receive MAC on in promiscuous mode. Last, it enables the power-management wake event and sets the power-state field to D3.

Every output is a level that stays asserted once the sequencer reaches it. The one exception is the alternate clock select, which drops again at the end of the clock handover. The handover keeps the alternate clock selected while the PLL low-power request rises. It releases the alternate clock only after a settle interval of at least 27 µs. A down counter clocked from the block's own reference times that interval, and the cycle count is rounded up from the reference frequency. A done flag marks the end of the sequence and stays set until a synchronous reset.

Top module: `lp_entry_seq`

## Requirements
- R1: While `rst` is high, and in the first cycle after it, every output is low and `pwr_state` reads 2'b00 (D0).
- R2: A high `start` sampled while the block is idle sets `rxcpu_clk_off` at that clock edge. No other output changes at that edge.
- R3: `alt_clk_sel` rises one cycle after `rxcpu_clk_off` rises.
- R4: `pll_lowpwr` rises one cycle after `alt_clk_sel` rises, and `alt_clk_sel` is high in that cycle.
- R5: `alt_clk_sel` falls exactly W cycles after `pll_lowpwr` rises. W = ceil(SETTLE_US × CLK_KHZ / 1000), which is 68 with the defaults.
- R6: `aux_pwr_req` rises one cycle after `alt_clk_sel` falls.
- R7: `rxmac_en` and `rxmac_promisc` rise together one cycle after `aux_pwr_req` rises.
- R8: `pme_en` and `seq_done` rise one cycle after the MAC outputs. In the same cycle `pwr_state` moves from 2'b00 to 2'b11 (D3), and it never holds any other code.
- R9: Once set, `rxcpu_clk_off`, `pll_lowpwr`, `aux_pwr_req`, the MAC outputs, `pme_en`, `pwr_state` and `seq_done` keep their values until reset.
- R10: A `start` pulse while the sequence is running, or after it has finished, has no effect on any output.
- R11: A reset asserted during the sequence returns every output to its R1 value, and a later `start` runs the full sequence from the beginning.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock, also the time base for the settle counter |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle request to begin the low-power entry |
| rxcpu_clk_off | output | 1 | Halts and clock-gates the receive processor |
| alt_clk_sel | output | 1 | Selects the alternate clock for internal logic |
| pll_lowpwr | output | 1 | Requests the PLL low-power mode |
| aux_pwr_req | output | 1 | Requests the switch from main to auxiliary power |
| rxmac_en | output | 1 | Enables the receive MAC |
| rxmac_promisc | output | 1 | Puts the receive MAC in promiscuous mode |
| pme_en | output | 1 | Enables the power-management wake event |
| pwr_state | output | 2 | Power state: 2'b00 = D0, 2'b11 = D3 |
| seq_done | output | 1 | Sequence complete, held until reset |

## Verification
The hardest stimuli to produce are a reset that lands in the middle of the settle wait and a `start` pulse that arrives while that wait is still counting. Both need the bench to aim at one particular window of the roughly seventy-cycle handover. The bench counts edges from the accepting `start` and fires these events at chosen offsets inside the window. A reference model, built only on that edge count, predicts every output level on every cycle. The mid-wait reset is followed by a full second run, which shows that the settle counter reloads and does not carry over a stale count.

// File: rtl/lpe_pkg.sv
package lpe_pkg;

    typedef enum logic [2:0] {
        STEP_IDLE     = 3'd0,
        STEP_CPU_HALT = 3'd1,
        STEP_ALT_ON   = 3'd2,
        STEP_PLL_WAIT = 3'd3,
        STEP_ALT_OFF  = 3'd4,
        STEP_AUX_REQ  = 3'd5,
        STEP_MAC_ON   = 3'd6,
        STEP_FINAL    = 3'd7
    } lpe_step_e;

    localparam logic [1:0] PSTATE_D0 = 2'b00;
    localparam logic [1:0] PSTATE_D3 = 2'b11;

    typedef struct packed {
        logic       rxcpu_clk_off;
        logic       alt_clk_sel;
        logic       pll_lowpwr;
        logic       aux_pwr_req;
        logic       rxmac_en;
        logic       rxmac_promisc;
        logic       pme_en;
        logic [1:0] pwr_state;
        logic       seq_done;
    } lpe_ctrl_t;

    // Reference cycles covering a wait of usec microseconds, rounded up.
    function automatic int unsigned settle_cycles(int unsigned usec, int unsigned clk_khz);
        int unsigned prod;
        prod = usec * clk_khz;
        return (prod + 999) / 1000;
    endfunction

endpackage

// File: rtl/lpe_settle_timer.sv
module lpe_settle_timer #(
    parameter int unsigned WAIT_CYC = 68,
    localparam int unsigned CNT_W   = $clog2(WAIT_CYC + 1)
) (
    input  logic clk,
    input  logic rst,
    input  logic load,
    input  logic dec,
    output logic expired
);
    logic [CNT_W-1:0] remain;

    always_ff @(posedge clk) begin
        if (rst) begin
            remain <= '0;
        end else if (load) begin
            remain <= CNT_W'(WAIT_CYC - 1);
        end else if (dec && (remain != '0)) begin
            remain <= remain - 1'b1;
        end
    end

    assign expired = (remain == '0);
endmodule

// File: rtl/lpe_step_fsm.sv
module lpe_step_fsm
    import lpe_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      start,
    input  logic      tmr_expired,
    output logic      tmr_load,
    output logic      tmr_dec,
    output lpe_step_e step
);
    lpe_step_e step_nx;

    always_comb begin
        step_nx  = step;
        tmr_load = 1'b0;
        tmr_dec  = 1'b0;
        unique case (step)
            STEP_IDLE:     if (start) step_nx = STEP_CPU_HALT;
            STEP_CPU_HALT: step_nx = STEP_ALT_ON;
            STEP_ALT_ON: begin
                step_nx  = STEP_PLL_WAIT;
                tmr_load = 1'b1;
            end
            STEP_PLL_WAIT: begin
                tmr_dec = 1'b1;
                if (tmr_expired) step_nx = STEP_ALT_OFF;
            end
            STEP_ALT_OFF:  step_nx = STEP_AUX_REQ;
            STEP_AUX_REQ:  step_nx = STEP_MAC_ON;
            STEP_MAC_ON:   step_nx = STEP_FINAL;
            STEP_FINAL:    step_nx = STEP_FINAL;
            default:       step_nx = STEP_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) step <= STEP_IDLE;
        else     step <= step_nx;
    end
endmodule

// File: rtl/lpe_out_decode.sv
module lpe_out_decode
    import lpe_pkg::*;
(
    input  lpe_step_e step,
    output lpe_ctrl_t ctrl
);
    always_comb begin
        ctrl               = '0;
        ctrl.rxcpu_clk_off = (step != STEP_IDLE);
        ctrl.alt_clk_sel   = (step == STEP_ALT_ON) || (step == STEP_PLL_WAIT);
        ctrl.pll_lowpwr    = (step >= STEP_PLL_WAIT);
        ctrl.aux_pwr_req   = (step >= STEP_AUX_REQ);
        ctrl.rxmac_en      = (step >= STEP_MAC_ON);
        ctrl.rxmac_promisc = (step >= STEP_MAC_ON);
        ctrl.pme_en        = (step == STEP_FINAL);
        ctrl.pwr_state     = (step == STEP_FINAL) ? PSTATE_D3 : PSTATE_D0;
        ctrl.seq_done      = (step == STEP_FINAL);
    end
endmodule

// File: rtl/lp_entry_seq.sv
module lp_entry_seq
    import lpe_pkg::*;
#(
    parameter int unsigned CLK_KHZ   = 2500,
    parameter int unsigned SETTLE_US = 27,
    localparam int unsigned WAIT_CYC = settle_cycles(SETTLE_US, CLK_KHZ)
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       start,
    output logic       rxcpu_clk_off,
    output logic       alt_clk_sel,
    output logic       pll_lowpwr,
    output logic       aux_pwr_req,
    output logic       rxmac_en,
    output logic       rxmac_promisc,
    output logic       pme_en,
    output logic [1:0] pwr_state,
    output logic       seq_done
);
    lpe_step_e step;
    lpe_ctrl_t ctrl;
    logic      tmr_load;
    logic      tmr_dec;
    logic      tmr_expired;

    lpe_step_fsm u_fsm (
        .clk         (clk),
        .rst         (rst),
        .start       (start),
        .tmr_expired (tmr_expired),
        .tmr_load    (tmr_load),
        .tmr_dec     (tmr_dec),
        .step        (step)
    );

    lpe_settle_timer #(.WAIT_CYC(WAIT_CYC)) u_timer (
        .clk     (clk),
        .rst     (rst),
        .load    (tmr_load),
        .dec     (tmr_dec),
        .expired (tmr_expired)
    );

    lpe_out_decode u_dec (
        .step (step),
        .ctrl (ctrl)
    );

    assign rxcpu_clk_off = ctrl.rxcpu_clk_off;
    assign alt_clk_sel   = ctrl.alt_clk_sel;
    assign pll_lowpwr    = ctrl.pll_lowpwr;
    assign aux_pwr_req   = ctrl.aux_pwr_req;
    assign rxmac_en      = ctrl.rxmac_en;
    assign rxmac_promisc = ctrl.rxmac_promisc;
    assign pme_en        = ctrl.pme_en;
    assign pwr_state     = ctrl.pwr_state;
    assign seq_done      = ctrl.seq_done;
endmodule

// File: rtl/lpe_checker.sv
module lpe_checker #(
    parameter int unsigned CLK_KHZ   = 2500,
    parameter int unsigned SETTLE_US = 27
) (
    input logic       clk,
    input logic       rst,
    input logic       rxcpu_clk_off,
    input logic       alt_clk_sel,
    input logic       pll_lowpwr,
    input logic       aux_pwr_req,
    input logic       rxmac_en,
    input logic       rxmac_promisc,
    input logic       pme_en,
    input logic [1:0] pwr_state,
    input logic       seq_done
);
    localparam int unsigned WIN   = lpe_pkg::settle_cycles(SETTLE_US, CLK_KHZ);
    localparam int unsigned WIN_W = $clog2(WIN + 2);

    // Cycles spent with both PLL low-power and alternate clock active.
    logic [WIN_W-1:0] overlap;
    always_ff @(posedge clk) begin
        if (rst || !pll_lowpwr) overlap <= '0;
        else if (alt_clk_sel && (overlap != {WIN_W{1'b1}})) overlap <= overlap + 1'b1;
    end

    assert_cpu_first_R3: assert property (@(posedge clk) disable iff (rst)
        $rose(alt_clk_sel) |-> rxcpu_clk_off);

    assert_alt_under_pll_R4: assert property (@(posedge clk) disable iff (rst)
        $rose(pll_lowpwr) |-> alt_clk_sel);

    assert_settle_window_R5: assert property (@(posedge clk) disable iff (rst)
        $fell(alt_clk_sel) |-> (overlap == WIN_W'(WIN)));

    assert_aux_after_release_R6: assert property (@(posedge clk) disable iff (rst)
        $rose(aux_pwr_req) |-> (!alt_clk_sel && pll_lowpwr));

    assert_mac_pair_R7: assert property (@(posedge clk) disable iff (rst)
        rxmac_en == rxmac_promisc);

    assert_pstate_code_R8: assert property (@(posedge clk) disable iff (rst)
        (pwr_state != 2'b00) |-> (pwr_state == 2'b11 && pme_en && seq_done));

    assert_done_hold_R9: assert property (@(posedge clk) disable iff (rst)
        seq_done |=> (seq_done && pll_lowpwr && aux_pwr_req && rxmac_en));

    assert_pll_hold_R9: assert property (@(posedge clk) disable iff (rst)
        pll_lowpwr |=> pll_lowpwr);
endmodule

bind lp_entry_seq lpe_checker #(.CLK_KHZ(CLK_KHZ), .SETTLE_US(SETTLE_US)) u_lpe_chk (
    .clk           (clk),
    .rst           (rst),
    .rxcpu_clk_off (rxcpu_clk_off),
    .alt_clk_sel   (alt_clk_sel),
    .pll_lowpwr    (pll_lowpwr),
    .aux_pwr_req   (aux_pwr_req),
    .rxmac_en      (rxmac_en),
    .rxmac_promisc (rxmac_promisc),
    .pme_en        (pme_en),
    .pwr_state     (pwr_state),
    .seq_done      (seq_done)
);

// File: tb/test_lp_entry_seq.sv
module test_lp_entry_seq;
    localparam int CLK_PERIOD = 10;
    localparam int CLK_KHZ    = 2500;
    localparam int SETTLE_US  = 27;
    // Settle window from R5, rounded up: 68 cycles.
    localparam int W          = (SETTLE_US * CLK_KHZ + 999) / 1000;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       start = 1'b0;
    logic       rxcpu_clk_off, alt_clk_sel, pll_lowpwr, aux_pwr_req;
    logic       rxmac_en, rxmac_promisc, pme_en, seq_done;
    logic [1:0] pwr_state;

    int compared = 0;
    int mismatched = 0;
    int cyc = 0;
    int t = 0;          // model: 0 = idle, else edges since start was accepted
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    lp_entry_seq #(.CLK_KHZ(CLK_KHZ), .SETTLE_US(SETTLE_US)) i_lp_entry_seq (
        .clk(clk), .rst(rst), .start(start),
        .rxcpu_clk_off(rxcpu_clk_off), .alt_clk_sel(alt_clk_sel),
        .pll_lowpwr(pll_lowpwr), .aux_pwr_req(aux_pwr_req),
        .rxmac_en(rxmac_en), .rxmac_promisc(rxmac_promisc),
        .pme_en(pme_en), .pwr_state(pwr_state), .seq_done(seq_done)
    );

    task automatic check(string req, logic [1:0] act, logic [1:0] exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s at cycle %0d: actual %0b expected %0b", req, cyc, act, exp);
        end
    endtask

    // Reference model: behaviour expressed as a function of edge count t.
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (rst)                 t <= 0;
        else if (t == 0 && start) t <= 1;
        else if (t > 0 && t < 100000) t <= t + 1;
    end

    always @(negedge clk) begin
        if (!finished) begin
            check("R2 cpu clock off",      {1'b0, rxcpu_clk_off}, {1'b0, t >= 1});
            check("R3/R5 alt clock",       {1'b0, alt_clk_sel},   {1'b0, (t >= 2) && (t <= 2 + W)});
            check("R4 pll low power",      {1'b0, pll_lowpwr},    {1'b0, t >= 3});
            check("R6 aux power",          {1'b0, aux_pwr_req},   {1'b0, t >= 4 + W});
            check("R7 mac enable",         {1'b0, rxmac_en},      {1'b0, t >= 5 + W});
            check("R7 mac promisc",        {1'b0, rxmac_promisc}, {1'b0, t >= 5 + W});
            check("R8 pme enable",         {1'b0, pme_en},        {1'b0, t >= 6 + W});
            check("R8 power state",        pwr_state,             (t >= 6 + W) ? 2'b11 : 2'b00);
            check("R8 done flag",          {1'b0, seq_done},      {1'b0, t >= 6 + W});
        end
    end

    // Watchdog: an expired run counts as one failed check.
    always @(posedge clk) begin
        if (cyc > 20000 && !finished) begin
            finished = 1;
            mismatched++;
            compared++;
            $display("FAIL watchdog: actual cycle %0d expected below 20000", cyc);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    task automatic pulse_start();
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    initial begin
        // R1: reset state observed by the per-cycle model during reset.
        idle(4);
        @(negedge clk) rst = 1'b0;
        idle(5);
        check("R1 idle after reset", {1'b0, rxcpu_clk_off | seq_done}, 2'b00);

        // First run, with a stray start in the settle wait (R10).
        pulse_start();
        idle(10);
        pulse_start();
        idle(W + 10);
        check("R8 done reached", {1'b0, seq_done}, 2'b01);
        idle(20);
        // R9: levels still held well after completion.
        check("R9 hold pll", {1'b0, pll_lowpwr}, 2'b01);
        check("R9 hold state", pwr_state, 2'b11);
        // R10: start after completion is ignored.
        pulse_start();
        idle(3);
        check("R10 alt stays low", {1'b0, alt_clk_sel}, 2'b00);

        // R11: reset in the middle of the settle wait.
        @(negedge clk) rst = 1'b1;
        idle(2);
        @(negedge clk) rst = 1'b0;
        pulse_start();
        idle(30);
        check("R11 mid-wait alt high", {1'b0, alt_clk_sel}, 2'b01);
        @(negedge clk) rst = 1'b1;
        idle(1);
        @(negedge clk) rst = 1'b0;
        check("R11 outputs cleared", {rxcpu_clk_off | pll_lowpwr, seq_done}, 2'b00);
        idle(3);
        pulse_start();
        idle(W + 12);
        check("R11 full rerun done", {1'b0, seq_done}, 2'b01);
        idle(5);

        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule